// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a classic 8-bit microcontroller external memory bus. It creates the address-latch pulse (`ale`) and the active-low program-store read strobe (`psen_n`), and it exports a machine-cycle phase counter that other bus logic can decode. A machine cycle is 12 oscillator clocks in the standard mode and 6 in the fast mode. Each machine cycle holds two equal slots, and each slot can carry one address-latch pulse and one program-store read pulse.

The control inputs are a fast-mode select, a flag saying that code runs from external program memory, a flag saying that the current machine cycle accesses external data memory, and a mute bit for the address-latch strobe. All four are taken once per machine cycle, at the clock edge that returns the phase counter to zero, and they then apply to that whole machine cycle. When a cycle accesses external data, the second slot of that cycle carries neither strobe. This leaves the bus free for the data transfer.

Both strobes come straight from flip-flops and line up with the phase counter: a given phase value always appears together with the strobe levels that belong to it.

Top module: `bus_strobe_gen`

## Requirements
- R1: `mc_phase` counts up by one on every clock and returns to 0 after 11 in standard mode (`fast_mode`=0) or after 5 in fast mode (`fast_mode`=1). The mode in force is the one taken at the last return to 0.
- R2: With the mute bit clear, `ale` is high at phases 0, 1, 6 and 7 in standard mode and at phases 0 and 3 in fast mode, and low at all other phases. This gives an `ale` rate of one sixth, or one third, of the clock.
- R3: With external code execution, `psen_n` is low at phases 4, 5, 10 and 11 in standard mode and at phases 2 and 5 in fast mode. `ale` is never high while `psen_n` is low.
- R4: In a machine cycle taken with `data_ext`=1, the second slot carries no strobe: no `ale` at phases 6, 7 (standard) or 3 (fast), and no `psen_n` at phases 10, 11 (standard) or 5 (fast). Exactly one `ale` pulse and at most one `psen_n` pulse remain in that cycle.
- R5: In a machine cycle taken with `code_ext`=0, `psen_n` stays high for the whole cycle.
- R6: In a machine cycle taken with `ale_mute`=1, `ale` stays low for the whole cycle, and `psen_n` behaves as it would with the mute bit clear.
- R7: The four control inputs are taken only at the clock edge where `mc_phase` becomes 0. A change at any other time has no effect until the next machine cycle.
- R8: While `rst` is high, `mc_phase` is 0, `ale` is 0 and `psen_n` is 1. The first machine cycle after reset lasts 12 clocks and carries no strobe on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode | input | 1 | 1 = 6-clock machine cycle, 0 = 12-clock machine cycle |
| code_ext | input | 1 | 1 = code is fetched from external program memory |
| data_ext | input | 1 | 1 = the coming machine cycle accesses external data memory |
| ale_mute | input | 1 | 1 = hold the address-latch strobe low |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| mc_phase | output | 4 | Clock position within the machine cycle |

## Verification
A bench model follows the phase and the strobe levels on every clock, while directed runs count the strobe edges per machine cycle. External code fetch is run in both modes to confirm the one-sixth and one-third `ale` rates and the two read pulses per cycle. Single data-access cycles are run in each mode to show that the second-slot pulses are dropped and the first-slot pulses are kept. Internal execution and the mute bit are run apart from each other to show that each one silences only its own strobe. Control changes made in the middle of a cycle, and a mode change, show that the inputs are taken only at the cycle boundary.

// File: rtl/bsg_pkg.sv
`timescale 1ns/1ps
package bsg_pkg;

    localparam int unsigned SLOW_CLKS = 12;
    localparam int unsigned FAST_CLKS = 6;
    localparam int unsigned PH_W      = $clog2(SLOW_CLKS);

    typedef logic [PH_W-1:0] phase_t;

    typedef enum logic {
        MC_SLOW = 1'b0,
        MC_FAST = 1'b1
    } mc_mode_e;

    typedef struct packed {
        mc_mode_e mode;
        logic     code_ext;
        logic     data_ext;
        logic     ale_mute;
    } cyc_ctx_t;

    typedef struct packed {
        logic   second;
        phase_t off;
    } slot_pos_t;

    // First cycle after reset: standard length, no strobes at all.
    localparam cyc_ctx_t CTX_RESET = '{mode: MC_SLOW, code_ext: 1'b0,
                                       data_ext: 1'b0, ale_mute: 1'b1};

    function automatic phase_t last_phase(mc_mode_e m);
        return (m == MC_FAST) ? phase_t'(FAST_CLKS - 1) : phase_t'(SLOW_CLKS - 1);
    endfunction

    function automatic phase_t slot_len(mc_mode_e m);
        return (m == MC_FAST) ? phase_t'(FAST_CLKS / 2) : phase_t'(SLOW_CLKS / 2);
    endfunction

    // Pulse width: one third of a slot, i.e. one sixth of the machine cycle.
    function automatic phase_t pulse_len(mc_mode_e m);
        return (m == MC_FAST) ? phase_t'(FAST_CLKS / 6) : phase_t'(SLOW_CLKS / 6);
    endfunction

    function automatic slot_pos_t locate(phase_t ph, mc_mode_e m);
        slot_pos_t p;
        p.second = (ph >= slot_len(m));
        p.off    = p.second ? phase_t'(ph - slot_len(m)) : ph;
        return p;
    endfunction

endpackage

// File: rtl/bsg_cycle_seq.sv
`timescale 1ns/1ps
module bsg_cycle_seq
    import bsg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mc_mode_e mode_in,
    input  logic     code_in,
    input  logic     data_in,
    input  logic     mute_in,
    output phase_t   phase_q,
    output phase_t   phase_nx,
    output cyc_ctx_t ctx_q,
    output cyc_ctx_t ctx_nx
);

    logic wrap;

    always_comb begin
        wrap     = (phase_q == last_phase(ctx_q.mode));
        phase_nx = wrap ? '0 : phase_t'(phase_q + 1'b1);
        ctx_nx   = ctx_q;
        if (wrap) begin
            ctx_nx.mode     = mode_in;
            ctx_nx.code_ext = code_in;
            ctx_nx.data_ext = data_in;
            ctx_nx.ale_mute = mute_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            ctx_q   <= CTX_RESET;
        end else begin
            phase_q <= phase_nx;
            ctx_q   <= ctx_nx;
        end
    end

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst) // R1
        (phase_q != '0) |-> (phase_q == phase_t'($past(phase_q) + 1'b1)));

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst) // R1
        phase_q <= last_phase(ctx_q.mode));

    AST_CTX_HOLD: assert property (@(posedge clk) disable iff (rst) // R7
        (phase_q != '0) |-> $stable(ctx_q));

endmodule

// File: rtl/bsg_strobe_dec.sv
`timescale 1ns/1ps
module bsg_strobe_dec
    import bsg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  phase_t   phase_nx,
    input  cyc_ctx_t ctx_nx,
    input  phase_t   phase_q,
    input  cyc_ctx_t ctx_q,
    output logic     ale_q,
    output logic     psen_nq
);

    slot_pos_t pos_nx;
    slot_pos_t pos_q;
    phase_t    width_nx;
    logic      slot_dropped;
    logic      ale_d;
    logic      psen_n_d;

    always_comb begin
        pos_nx       = locate(phase_nx, ctx_nx.mode);
        width_nx     = pulse_len(ctx_nx.mode);
        slot_dropped = pos_nx.second && ctx_nx.data_ext;
        ale_d        = !ctx_nx.ale_mute && (pos_nx.off < width_nx) && !slot_dropped;
        psen_n_d     = !(ctx_nx.code_ext && (pos_nx.off >= phase_t'(2 * width_nx))
                         && !slot_dropped);
        pos_q        = locate(phase_q, ctx_q.mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q   <= 1'b0;
            psen_nq <= 1'b1;
        end else begin
            ale_q   <= ale_d;
            psen_nq <= psen_n_d;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) // R3
        ale_q |-> psen_nq);

    AST_XDATA_DROP: assert property (@(posedge clk) disable iff (rst) // R4
        (ctx_q.data_ext && pos_q.second) |-> (!ale_q && psen_nq));

    AST_INTERNAL_QUIET: assert property (@(posedge clk) disable iff (rst) // R5
        !ctx_q.code_ext |-> psen_nq);

    AST_MUTE_LOW: assert property (@(posedge clk) disable iff (rst) // R6
        ctx_q.ale_mute |-> !ale_q);

endmodule

// File: rtl/bus_strobe_gen.sv
`timescale 1ns/1ps
module bus_strobe_gen
    import bsg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fast_mode,
    input  logic            code_ext,
    input  logic            data_ext,
    input  logic            ale_mute,
    output logic            ale,
    output logic            psen_n,
    output logic [PH_W-1:0] mc_phase
);

    phase_t   phase_q;
    phase_t   phase_nx;
    cyc_ctx_t ctx_q;
    cyc_ctx_t ctx_nx;
    mc_mode_e mode_sel;

    assign mode_sel = fast_mode ? MC_FAST : MC_SLOW;

    bsg_cycle_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (mode_sel),
        .code_in  (code_ext),
        .data_in  (data_ext),
        .mute_in  (ale_mute),
        .phase_q  (phase_q),
        .phase_nx (phase_nx),
        .ctx_q    (ctx_q),
        .ctx_nx   (ctx_nx)
    );

    bsg_strobe_dec u_dec (
        .clk      (clk),
        .rst      (rst),
        .phase_nx (phase_nx),
        .ctx_nx   (ctx_nx),
        .phase_q  (phase_q),
        .ctx_q    (ctx_q),
        .ale_q    (ale),
        .psen_nq  (psen_n)
    );

    assign mc_phase = phase_q;

    AST_RESET_IDLE: assert property (@(posedge clk) // R8
        $past(rst) |-> (mc_phase == '0 && !ale && psen_n));

endmodule

// File: tb/sim_bus_strobe_gen.sv
`timescale 1ns/1ps
module sim_bus_strobe_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fast_mode = 1'b0;
    logic       code_ext = 1'b0;
    logic       data_ext = 1'b0;
    logic       ale_mute = 1'b0;
    logic       ale;
    logic       psen_n;
    logic [3:0] mc_phase;

    int checks = 0;
    int errors = 0;

    // bench model state
    int   m_phase = 0;
    logic m_fast = 1'b0, m_code = 1'b0, m_data = 1'b0, m_mute = 1'b1;
    logic prev_ale = 1'b0, prev_psen = 1'b1;
    int   rises = 0, falls = 0;

    bus_strobe_gen u0 (
        .clk(clk), .rst(rst), .fast_mode(fast_mode), .code_ext(code_ext),
        .data_ext(data_ext), .ale_mute(ale_mute), .ale(ale), .psen_n(psen_n),
        .mc_phase(mc_phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one clock: model advance at the edge, compare at the next falling edge
    task automatic step();
        int   lastp, half, w, off;
        logic second, e_ale, e_psen;
        string ta, tp;
        @(posedge clk);
        lastp = m_fast ? 5 : 11;
        if (m_phase == lastp) begin
            m_phase = 0;
            m_fast = fast_mode; m_code = code_ext; m_data = data_ext; m_mute = ale_mute;
        end else begin
            m_phase++;
        end
        half   = m_fast ? 3 : 6;
        w      = half / 3;
        second = (m_phase >= half);
        off    = second ? m_phase - half : m_phase;
        e_ale  = !m_mute && (off < w) && !(second && m_data);
        e_psen = !(m_code && (off >= 2*w) && !(second && m_data));
        ta = m_mute ? "R6" : ((second && m_data) ? "R4" : "R2");
        tp = !m_code ? "R5" : ((second && m_data) ? "R4" : "R3");
        @(negedge clk);
        chk("R1", int'(mc_phase), m_phase, "phase");
        chk(ta, int'(ale), int'(e_ale), "ale");
        chk(tp, int'(psen_n), int'(e_psen), "psen_n");
        if (ale && !prev_ale) rises++;
        if (!psen_n && prev_psen) falls++;
        prev_ale = ale;
        prev_psen = psen_n;
    endtask

    task automatic align();
        while (m_phase != (m_fast ? 5 : 11)) step();
    endtask

    task automatic run(int n);
        rises = 0; falls = 0;
        repeat (n) step();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8", int'(mc_phase), 0, "phase in reset");
        chk("R8", int'(ale), 0, "ale in reset");
        chk("R8", int'(psen_n), 1, "psen_n in reset");
        code_ext = 1'b1;
        rst = 1'b0;
        run(11);
        chk("R8", rises, 0, "ale pulses in first cycle");
        chk("R8", falls, 0, "psen pulses in first cycle");
        chk("R8", int'(mc_phase), 11, "first cycle length");
    endtask

    task automatic t_fetch_slow();
        align();
        fast_mode = 1'b0; code_ext = 1'b1; data_ext = 1'b0; ale_mute = 1'b0;
        run(48);
        chk("R2", rises, 8, "ale pulses in 48 clocks, standard");
        chk("R3", falls, 8, "psen pulses in 48 clocks, standard");
    endtask

    task automatic t_fetch_fast();
        align();
        fast_mode = 1'b1;
        run(24);
        chk("R2", rises, 8, "ale pulses in 24 clocks, fast");
        chk("R3", falls, 8, "psen pulses in 24 clocks, fast");
    endtask

    task automatic t_xdata(int len);
        align();
        data_ext = 1'b1;
        run(len);
        chk("R4", rises, 1, "ale pulses in data cycle");
        chk("R4", falls, 1, "psen pulses in data cycle");
        data_ext = 1'b0;
        run(len);
        chk("R4", rises, 2, "ale pulses in cycle after data cycle");
    endtask

    task automatic t_mode_back();
        align();
        fast_mode = 1'b0;
        run(12);
        chk("R1", int'(mc_phase), 11, "standard length after mode change");
    endtask

    task automatic t_internal();
        align();
        code_ext = 1'b0;
        run(12);
        chk("R5", falls, 0, "psen pulses while internal");
        chk("R5", rises, 2, "ale pulses while internal");
        code_ext = 1'b1;
    endtask

    task automatic t_mute();
        align();
        ale_mute = 1'b1;
        run(12);
        chk("R6", rises, 0, "ale pulses while muted");
        chk("R6", falls, 2, "psen pulses while muted");
        ale_mute = 1'b0;
    endtask

    task automatic t_sample();
        align();
        step();
        data_ext = 1'b1; ale_mute = 1'b1; code_ext = 1'b0; fast_mode = 1'b1;
        rises = 0; falls = 0;
        repeat (11) step();
        chk("R7", rises, 1, "ale pulses after mid-cycle change");
        chk("R7", falls, 2, "psen pulses after mid-cycle change");
        chk("R7", int'(mc_phase), 11, "cycle length after mid-cycle change");
        data_ext = 1'b0; ale_mute = 1'b0; code_ext = 1'b1; fast_mode = 1'b0;
        run(12);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fetch_slow();
        t_fetch_fast();
        t_xdata(6);
        t_mode_back();
        t_xdata(12);
        t_internal();
        t_mute();
        t_sample();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule